// File: doc/BRIEF.md
# Register Bank Self-Test Sequencer

This block is a hardware test controller for a group of identical register-holding chips that share one address, write-data and read-data bus, each chip with its own select line. After a one-cycle `start` pulse it walks through four phases in a fixed order. The pattern phase fills every register of every chip with a test word and reads all of them back, once for each of four words. The reset phase pulses a shared clear line and verifies every register's initial value. The address phase stores each register's own index in that register and then reads everything back, so that address bits which are shorted together or stuck open cause aliasing and show up as mismatches. The chip-select phase writes a word unique to one chip and then reads all chips back, so that a write reaching the wrong chip is detected.

Every read returns data one cycle after the read strobe. The first wrong value ends the run. The controller then latches the phase code, chip index, register index, expected word and observed word. A clean run ends with `done` and `pass_ok` both high. All results stay valid until the next `start`.

Top module: `regbank_selftest`

## Requirements
- R1: While `rst` is high and in the cycle after it, `busy`, `done` and `pass_ok` are 0. The bus is idle: `bus_cs` is 0 and `bus_we`, `bus_re` and `bus_rst` are 0. Asserting `rst` in the middle of a run stops the run.
- R2: A `start` pulse while `busy` is low raises `busy` in the next cycle and clears `done` and `pass_ok`. The phases run in this order: pattern (code 0), reset (code 1), address (code 2), chip-select (code 3).
- R3: The pattern phase uses four words in this order: all zeros, all ones, alternating bits with bit 0 set (0x55 at width 8), and its complement (0xAA). For each word it writes every register of every chip, with chips in the outer loop and registers in the inner loop, and then reads all of them back in the same order. This makes 512 bus accesses at the default sizes.
- R4: The reset phase drives `bus_rst` for exactly one cycle with no chip selected and no access. It then reads every register and expects `RESET_VAL` (0 by default).
- R5: The address phase writes the register index, truncated to the data width, into each register of each chip. It then reads all registers back and expects those values.
- R6: The chip-select phase has one round for each chip k, in increasing order of k. Each round writes the inverse of k into all registers of chip k only. It then reads all chips: chips 0 to k must hold the inverse of their own index, and the other chips must still hold their register index. At the default sizes this phase makes 320 accesses, and the whole run makes 1024.
- R7: Read data is compared in the cycle that follows the cycle in which `bus_re` is high.
- R8: On the first mismatch, `busy` falls and `done` rises with `pass_ok` low. At the same time the controller latches `fail_phase`, `fail_chip`, `fail_reg`, `fail_exp` and `fail_obs`. No bus access follows.
- R9: A run with no mismatch ends with `done` and `pass_ok` both high. `done`, `pass_ok` and the fail fields hold their values until the next `start`.
- R10: At most one chip select is active at a time. Every write or read has exactly one select active, and `bus_we` and `bus_re` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a run |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | High once a run has finished |
| pass_ok | output | 1 | High when the finished run found no mismatch |
| fail_phase | output | 2 | Phase code of the first mismatch |
| fail_chip | output | $clog2(NUM_CHIPS) | Chip index of the first mismatch |
| fail_reg | output | $clog2(REGS_PER_CHIP) | Register index of the first mismatch |
| fail_exp | output | DATA_W | Expected word at the first mismatch |
| fail_obs | output | DATA_W | Observed word at the first mismatch |
| bus_cs | output | NUM_CHIPS | One-hot chip selects |
| bus_addr | output | $clog2(REGS_PER_CHIP) | Register address |
| bus_we | output | 1 | Write strobe |
| bus_re | output | 1 | Read strobe |
| bus_rst | output | 1 | Clear-all-registers strobe |
| bus_wdata | output | DATA_W | Write data, which also carries the expected word during reads |
| bus_rdata | input | DATA_W | Read data from the selected chip, one cycle after `bus_re` |

## Verification
A behavioural bank model is run once without faults and once with each of eight injected faults. The faults are a stuck-low data bit, a stuck-high data bit, an ignored clear, a wrong clear value in one register, two address bits wired together, an address bit stuck open, and a select that leaks into a higher chip or into a lower chip. Each fault is caught in the phase built to expose it, and the bench checks the exact chip, register and pair of words reported. The stuck bits show that the four pattern words separate stuck-low from stuck-high. The two leak directions show that one round per chip, followed by a read of all chips, catches a leak in either direction. The fault-free run is traced on the bus to confirm the order of the pattern words, the position of the single clear pulse, the index data of the address phase, and the per-chip data of the rounds.

// File: rtl/rbst_pkg.sv
package rbst_pkg;

  typedef enum logic [1:0] {
    PH_PATTERN = 2'd0,
    PH_RESET   = 2'd1,
    PH_ADDR    = 2'd2,
    PH_CSEL    = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    K_WRITE_ALL = 2'd0,
    K_READ_ALL  = 2'd1,
    K_WRITE_ONE = 2'd2,
    K_CLEAR     = 2'd3
  } kind_e;

endpackage

// File: rtl/rbst_plan.sv
// Maps (phase, pass) to the kind of sweep and whether it is the phase's last pass.
module rbst_plan
  import rbst_pkg::*;
#(
  parameter int NUM_CHIPS = 4,
  parameter int PASS_W    = 3
) (
  input  phase_e            phase,
  input  logic [PASS_W-1:0] pass_idx,
  output kind_e             kind,
  output logic              last_pass
);

  localparam logic [PASS_W-1:0] PAT_LAST = PASS_W'(7);
  localparam logic [PASS_W-1:0] CS_LAST  = PASS_W'(2 * NUM_CHIPS - 1);

  always_comb begin
    kind      = K_READ_ALL;
    last_pass = 1'b0;
    unique case (phase)
      PH_PATTERN: begin
        kind      = pass_idx[0] ? K_READ_ALL : K_WRITE_ALL;
        last_pass = (pass_idx == PAT_LAST);
      end
      PH_RESET: begin
        kind      = pass_idx[0] ? K_READ_ALL : K_CLEAR;
        last_pass = (pass_idx == PASS_W'(1));
      end
      PH_ADDR: begin
        kind      = pass_idx[0] ? K_READ_ALL : K_WRITE_ALL;
        last_pass = (pass_idx == PASS_W'(1));
      end
      PH_CSEL: begin
        kind      = pass_idx[0] ? K_READ_ALL : K_WRITE_ONE;
        last_pass = (pass_idx == CS_LAST);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/rbst_expect.sv
// Word to write, or to expect on read, for a given phase, pass, chip and register.
module rbst_expect
  import rbst_pkg::*;
#(
  parameter int              DATA_W    = 8,
  parameter int              CHIP_W    = 2,
  parameter int              REG_W     = 4,
  parameter int              PASS_W    = 3,
  parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
  input  phase_e            phase,
  input  logic [PASS_W-1:0] pass_idx,
  input  logic [CHIP_W-1:0] chip,
  input  logic [REG_W-1:0]  reg_idx,
  output logic [DATA_W-1:0] word
);

  function automatic logic [DATA_W-1:0] alt_word();
    logic [DATA_W-1:0] w;
    for (int i = 0; i < DATA_W; i++) w[i] = (i % 2 == 0);
    return w;
  endfunction

  localparam logic [DATA_W-1:0] ALT = alt_word();

  logic [PASS_W-1:0] round;
  logic [1:0]        pat_sel;

  assign round   = pass_idx >> 1;
  assign pat_sel = pass_idx[2:1];

  always_comb begin
    word = '0;
    unique case (phase)
      PH_PATTERN: begin
        unique case (pat_sel)
          2'd0: word = '0;
          2'd1: word = '1;
          2'd2: word = ALT;
          2'd3: word = ~ALT;
          default: ;
        endcase
      end
      PH_RESET: word = RESET_VAL;
      PH_ADDR:  word = DATA_W'(reg_idx);
      PH_CSEL: begin
        if (int'(chip) <= int'(round)) word = ~DATA_W'(chip);
        else                           word = DATA_W'(reg_idx);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/rbst_cmp.sv
// One-stage read pipeline: holds the coordinates of an issued read and compares
// the returned word in the following cycle.
module rbst_cmp #(
  parameter int DATA_W = 8,
  parameter int CHIP_W = 2,
  parameter int REG_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_issued,
  input  logic [1:0]        rd_phase,
  input  logic [CHIP_W-1:0] rd_chip,
  input  logic [REG_W-1:0]  rd_reg,
  input  logic [DATA_W-1:0] rd_exp,
  input  logic [DATA_W-1:0] rdata,
  output logic              pending,
  output logic              mismatch,
  output logic [1:0]        m_phase,
  output logic [CHIP_W-1:0] m_chip,
  output logic [REG_W-1:0]  m_reg,
  output logic [DATA_W-1:0] m_exp,
  output logic [DATA_W-1:0] m_obs
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      m_phase <= '0;
      m_chip  <= '0;
      m_reg   <= '0;
      m_exp   <= '0;
    end else begin
      pending <= rd_issued;
      if (rd_issued) begin
        m_phase <= rd_phase;
        m_chip  <= rd_chip;
        m_reg   <= rd_reg;
        m_exp   <= rd_exp;
      end
    end
  end

  assign m_obs    = rdata;
  assign mismatch = pending && (rdata != m_exp);

endmodule

// File: rtl/regbank_selftest.sv
module regbank_selftest
  import rbst_pkg::*;
#(
  parameter int                NUM_CHIPS     = 4,
  parameter int                REGS_PER_CHIP = 16,
  parameter int                DATA_W        = 8,
  parameter logic [DATA_W-1:0] RESET_VAL     = '0,
  localparam int               CHIP_W        = $clog2(NUM_CHIPS),
  localparam int               REG_W         = $clog2(REGS_PER_CHIP)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  output logic                 busy,
  output logic                 done,
  output logic                 pass_ok,
  output logic [1:0]           fail_phase,
  output logic [CHIP_W-1:0]    fail_chip,
  output logic [REG_W-1:0]     fail_reg,
  output logic [DATA_W-1:0]    fail_exp,
  output logic [DATA_W-1:0]    fail_obs,
  output logic [NUM_CHIPS-1:0] bus_cs,
  output logic [REG_W-1:0]     bus_addr,
  output logic                 bus_we,
  output logic                 bus_re,
  output logic                 bus_rst,
  output logic [DATA_W-1:0]    bus_wdata,
  input  logic [DATA_W-1:0]    bus_rdata
);

  localparam int PASS_CS = $clog2(2 * NUM_CHIPS);
  localparam int PASS_W  = (PASS_CS > 3) ? PASS_CS : 3;
  localparam logic [CHIP_W-1:0] LAST_CHIP = CHIP_W'(NUM_CHIPS - 1);
  localparam logic [REG_W-1:0]  LAST_REG  = REG_W'(REGS_PER_CHIP - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN} state_e;

  state_e            state_q;
  phase_e            phase_q;
  logic [PASS_W-1:0] pass_q;
  logic [CHIP_W-1:0] chip_q;
  logic [REG_W-1:0]  reg_q;

  // issued-access coordinates, registered with the bus
  logic [1:0]        iss_phase_q;
  logic [CHIP_W-1:0] iss_chip_q;

  kind_e             kind;
  logic              last_pass;
  logic [CHIP_W-1:0] tgt_chip;
  logic [DATA_W-1:0] word;
  logic              end_of_pass;

  logic              pending, mismatch;
  logic [1:0]        m_phase;
  logic [CHIP_W-1:0] m_chip;
  logic [REG_W-1:0]  m_reg;
  logic [DATA_W-1:0] m_exp, m_obs;

  rbst_plan #(.NUM_CHIPS(NUM_CHIPS), .PASS_W(PASS_W)) u_plan (
    .phase     (phase_q),
    .pass_idx  (pass_q),
    .kind      (kind),
    .last_pass (last_pass)
  );

  assign tgt_chip = (kind == K_WRITE_ONE) ? CHIP_W'(pass_q >> 1) : chip_q;

  rbst_expect #(
    .DATA_W(DATA_W), .CHIP_W(CHIP_W), .REG_W(REG_W),
    .PASS_W(PASS_W), .RESET_VAL(RESET_VAL)
  ) u_expect (
    .phase    (phase_q),
    .pass_idx (pass_q),
    .chip     (tgt_chip),
    .reg_idx  (reg_q),
    .word     (word)
  );

  rbst_cmp #(.DATA_W(DATA_W), .CHIP_W(CHIP_W), .REG_W(REG_W)) u_cmp (
    .clk       (clk),
    .rst       (rst),
    .rd_issued (bus_re),
    .rd_phase  (iss_phase_q),
    .rd_chip   (iss_chip_q),
    .rd_reg    (bus_addr),
    .rd_exp    (bus_wdata),
    .rdata     (bus_rdata),
    .pending   (pending),
    .mismatch  (mismatch),
    .m_phase   (m_phase),
    .m_chip    (m_chip),
    .m_reg     (m_reg),
    .m_exp     (m_exp),
    .m_obs     (m_obs)
  );

  assign end_of_pass = (kind == K_CLEAR) ||
                       ((reg_q == LAST_REG) &&
                        ((kind == K_WRITE_ONE) || (chip_q == LAST_CHIP)));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= S_IDLE;
      phase_q     <= PH_PATTERN;
      pass_q      <= '0;
      chip_q      <= '0;
      reg_q       <= '0;
      busy        <= 1'b0;
      done        <= 1'b0;
      pass_ok     <= 1'b0;
      fail_phase  <= '0;
      fail_chip   <= '0;
      fail_reg    <= '0;
      fail_exp    <= '0;
      fail_obs    <= '0;
      bus_cs      <= '0;
      bus_addr    <= '0;
      bus_we      <= 1'b0;
      bus_re      <= 1'b0;
      bus_rst     <= 1'b0;
      bus_wdata   <= '0;
      iss_phase_q <= '0;
      iss_chip_q  <= '0;
    end else begin
      // bus defaults to idle every cycle
      bus_cs  <= '0;
      bus_we  <= 1'b0;
      bus_re  <= 1'b0;
      bus_rst <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (start) begin
            state_q    <= S_RUN;
            phase_q    <= PH_PATTERN;
            pass_q     <= '0;
            chip_q     <= '0;
            reg_q      <= '0;
            busy       <= 1'b1;
            done       <= 1'b0;
            pass_ok    <= 1'b0;
            fail_phase <= '0;
            fail_chip  <= '0;
            fail_reg   <= '0;
            fail_exp   <= '0;
            fail_obs   <= '0;
          end
        end
        S_RUN, S_DRAIN: begin
          if (mismatch) begin
            state_q    <= S_IDLE;
            busy       <= 1'b0;
            done       <= 1'b1;
            pass_ok    <= 1'b0;
            fail_phase <= m_phase;
            fail_chip  <= m_chip;
            fail_reg   <= m_reg;
            fail_exp   <= m_exp;
            fail_obs   <= m_obs;
          end else if (state_q == S_DRAIN) begin
            if (!bus_re && !pending) begin
              state_q <= S_IDLE;
              busy    <= 1'b0;
              done    <= 1'b1;
              pass_ok <= 1'b1;
            end
          end else begin
            // issue the current access
            bus_rst     <= (kind == K_CLEAR);
            bus_we      <= (kind == K_WRITE_ALL) || (kind == K_WRITE_ONE);
            bus_re      <= (kind == K_READ_ALL);
            bus_cs      <= (kind == K_CLEAR) ? '0 : (NUM_CHIPS'(1) << tgt_chip);
            bus_addr    <= reg_q;
            bus_wdata   <= word;
            iss_phase_q <= phase_q;
            iss_chip_q  <= tgt_chip;
            // advance the sweep
            if (end_of_pass) begin
              chip_q <= '0;
              reg_q  <= '0;
              if (last_pass) begin
                pass_q <= '0;
                if (phase_q == PH_CSEL) state_q <= S_DRAIN;
                else                    phase_q <= phase_e'(phase_q + 2'd1);
              end else begin
                pass_q <= pass_q + PASS_W'(1);
              end
            end else if (reg_q == LAST_REG) begin
              reg_q  <= '0;
              chip_q <= chip_q + CHIP_W'(1);
            end else begin
              reg_q <= reg_q + REG_W'(1);
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/regbank_selftest_chk.sv
module regbank_selftest_chk #(
  parameter int NUM_CHIPS = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 start,
  input logic                 busy,
  input logic                 done,
  input logic                 pass_ok,
  input logic [NUM_CHIPS-1:0] bus_cs,
  input logic                 bus_we,
  input logic                 bus_re,
  input logic                 bus_rst
);

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bus_cs)); // R10
  AST_WE_RE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_re)); // R10
  AST_ACCESS_SELECTS: assert property (@(posedge clk) disable iff (rst)
    (bus_we || bus_re) |-> $countones(bus_cs) == 1); // R10
  AST_CLEAR_ALONE: assert property (@(posedge clk) disable iff (rst)
    bus_rst |-> (bus_cs == '0) && !bus_we && !bus_re); // R4
  AST_CLEAR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    bus_rst |=> !bus_rst); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !bus_we && !bus_re && !bus_rst); // R8
  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy && !done); // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done && $stable(pass_ok)); // R9
  AST_PASS_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
    pass_ok |-> done); // R9

endmodule

bind regbank_selftest regbank_selftest_chk #(.NUM_CHIPS(NUM_CHIPS)) u_chk (.*);

// File: tb/regbank_selftest_tb.sv
module regbank_selftest_tb;

  localparam int NC = 4;
  localparam int NR = 16;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          busy, done, pass_ok;
  logic [1:0]    fail_phase;
  logic [1:0]    fail_chip;
  logic [3:0]    fail_reg;
  logic [DW-1:0] fail_exp, fail_obs;
  logic [NC-1:0] bus_cs;
  logic [3:0]    bus_addr;
  logic          bus_we, bus_re, bus_rst;
  logic [DW-1:0] bus_wdata, bus_rdata;

  always #4 clk = ~clk; // 125 MHz

  regbank_selftest #(.NUM_CHIPS(NC), .REGS_PER_CHIP(NR), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .pass_ok(pass_ok), .fail_phase(fail_phase), .fail_chip(fail_chip),
    .fail_reg(fail_reg), .fail_exp(fail_exp), .fail_obs(fail_obs),
    .bus_cs(bus_cs), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rst(bus_rst), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // ---------------- behavioural register bank with fault injection ----------
  // fault: 0 none, 1 bit0 stuck low at chip2 reg5, 2 bit7 stuck high at chip1 reg3,
  // 3 clear ignored, 4 chip2 reg7 clears to 0x01, 5 addr bit1 wired-OR bit0,
  // 6 addr bit3 open, 7 writes to chip1 leak into chip3, 8 chip3 leaks into chip0
  int            fault = 0;
  logic          wipe = 1'b0;
  logic [DW-1:0] mem [NC*NR];

  function automatic int phys(int a);
    if (fault == 5) return a | ((a & 1) << 1);
    if (fault == 6) return a & ~8;
    return a;
  endfunction

  always @(posedge clk) begin
    logic [DW-1:0] rd;
    rd = '0;
    if (wipe) begin
      for (int i = 0; i < NC*NR; i++) mem[i] <= 8'h3C;
    end else if (bus_rst) begin
      for (int i = 0; i < NC*NR; i++)
        if (fault != 3) mem[i] <= (fault == 4 && i == 2*NR + 7) ? 8'h01 : 8'h00;
    end else if (bus_we) begin
      for (int c = 0; c < NC; c++)
        if (bus_cs[c] || (fault == 7 && c == 3 && bus_cs[1]) ||
            (fault == 8 && c == 0 && bus_cs[3]))
          mem[c*NR + phys(int'(bus_addr))] <= bus_wdata;
    end
    if (bus_re) begin
      for (int c = 0; c < NC; c++)
        if (bus_cs[c]) begin
          rd = mem[c*NR + phys(int'(bus_addr))];
          if (fault == 1 && c == 2 && bus_addr == 4'd5) rd[0] = 1'b0;
          if (fault == 2 && c == 1 && bus_addr == 4'd3) rd[7] = 1'b1;
        end
    end
    bus_rdata <= rd;
  end

  // ---------------- bus trace monitor -----------------------------------------
  int            acc_n, rst_pulses, rst_at, addr_ok, cs_ok;
  logic [DW-1:0] pat_w [4];
  logic          pat_is_w [4];
  logic          mon_on = 1'b0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (bus_rst) begin rst_pulses++; rst_at = acc_n; end
      if (bus_we || bus_re) begin
        if (acc_n < 512 && acc_n % 128 == 0) begin
          pat_w[acc_n/128]    = bus_wdata;
          pat_is_w[acc_n/128] = bus_we;
        end
        if (acc_n >= 576 && acc_n < 640 && bus_we && bus_wdata == DW'(bus_addr))
          addr_ok++;
        if (acc_n >= 704 && ((acc_n - 704) % 80) < 16 && bus_we &&
            bus_cs == NC'(1) << ((acc_n - 704) / 80) &&
            bus_wdata == ~DW'((acc_n - 704) / 80))
          cs_ok++;
        acc_n++;
      end
    end
  end

  // ---------------- checking helpers ---------------------------------------------
  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_bank(input int f, output bit finished);
    @(negedge clk);
    fault = f;
    wipe  = 1'b1;
    @(negedge clk);
    wipe  = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    finished = 1'b0;
    for (int i = 0; i < 4000 && !finished; i++) begin
      if (done) finished = 1'b1;
      else @(negedge clk);
    end
  endtask

  typedef struct packed {
    logic [3:0] flt;
    logic [3:0] req;
    logic       ok;
    logic [1:0] ph;
    logic [1:0] ch;
    logic [3:0] rg;
    logic [7:0] ex;
    logic [7:0] ob;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{4'd0, 4'd9, 1'b1, 2'd0, 2'd0, 4'd0, 8'h00, 8'h00}, // R9 healthy bank
    '{4'd1, 4'd3, 1'b0, 2'd0, 2'd2, 4'd5, 8'hFF, 8'hFE}, // R3 stuck low, seen on all-ones
    '{4'd2, 4'd7, 1'b0, 2'd0, 2'd1, 4'd3, 8'h00, 8'h80}, // R7 stuck high, seen on zeros
    '{4'd3, 4'd4, 1'b0, 2'd1, 2'd0, 4'd0, 8'h00, 8'hAA}, // R4 clear ignored
    '{4'd4, 4'd4, 1'b0, 2'd1, 2'd2, 4'd7, 8'h00, 8'h01}, // R4 wrong clear value
    '{4'd5, 4'd5, 1'b0, 2'd2, 2'd0, 4'd1, 8'h01, 8'h03}, // R5 address bits shorted
    '{4'd6, 4'd5, 1'b0, 2'd2, 2'd0, 4'd0, 8'h00, 8'h08}, // R5 address bit open
    '{4'd7, 4'd6, 1'b0, 2'd3, 2'd3, 4'd0, 8'h00, 8'hFE}, // R6 upward select leak
    '{4'd8, 4'd6, 1'b0, 2'd3, 2'd0, 4'd0, 8'hFF, 8'hFC}  // R6 downward select leak
  };

  initial begin
    bit fin;
    string rq;
    // R1: reset state
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !pass_ok, "R1", "status after reset",
        {busy, done, pass_ok}, 0);
    chk(bus_cs == 0 && !bus_we && !bus_re && !bus_rst, "R1", "bus after reset",
        {bus_cs, bus_we, bus_re, bus_rst}, 0);

    // table of faults and expected first mismatch
    for (int v = 0; v < 9; v++) begin
      rq = $sformatf("R%0d", VECS[v].req);
      run_bank(int'(VECS[v].flt), fin);
      chk(fin, rq, $sformatf("vec %0d done", v), fin, 1);
      chk(pass_ok == VECS[v].ok, rq, $sformatf("vec %0d pass", v), pass_ok, VECS[v].ok);
      if (!VECS[v].ok) begin
        // R8: location and words of the first mismatch
        chk(fail_phase == VECS[v].ph, rq, $sformatf("vec %0d phase", v),
            fail_phase, VECS[v].ph);
        chk(fail_chip == VECS[v].ch, rq, $sformatf("vec %0d chip", v),
            fail_chip, VECS[v].ch);
        chk(fail_reg == VECS[v].rg, rq, $sformatf("vec %0d reg", v),
            fail_reg, VECS[v].rg);
        chk(fail_exp == VECS[v].ex && fail_obs == VECS[v].ob, rq,
            $sformatf("vec %0d exp/obs", v), {fail_exp, fail_obs},
            {VECS[v].ex, VECS[v].ob});
      end
    end

    // R8 and R9: after the last failing run, the bus stays quiet and results hold
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(!bus_we && !bus_re && bus_cs == 0 && !busy, "R8", "quiet after fail",
          {bus_cs, bus_we, bus_re, busy}, 0);
      chk(done && !pass_ok && fail_obs == 8'hFC, "R9", "fail result held",
          {done, pass_ok, fail_obs}, {2'b10, 8'hFC});
    end

    // R2..R6: bus trace of a healthy run
    acc_n = 0; rst_pulses = 0; rst_at = -1; addr_ok = 0; cs_ok = 0;
    mon_on = 1'b1;
    run_bank(0, fin);
    mon_on = 1'b0;
    chk(fin && pass_ok && fail_phase == 0, "R9", "healthy pass and cleared fields",
        {fin, pass_ok, fail_phase}, {2'b11, 2'b00});
    chk(pat_w[0] == 8'h00 && pat_w[1] == 8'hFF && pat_is_w[0] && pat_is_w[1], "R3",
        "first two pattern words", {pat_w[0], pat_w[1]}, 16'h00FF);
    chk(pat_w[2] == 8'h55 && pat_w[3] == 8'hAA && pat_is_w[2] && pat_is_w[3], "R3",
        "last two pattern words", {pat_w[2], pat_w[3]}, 16'h55AA);
    chk(rst_pulses == 1 && rst_at == 512, "R2", "single clear after pattern phase",
        rst_at, 512); // R4 position as well
    chk(addr_ok == 64, "R5", "index-valued writes", addr_ok, 64);
    chk(cs_ok == 64, "R6", "per-chip round writes", cs_ok, 64);
    chk(acc_n == 1024, "R6", "total accesses", acc_n, 1024);

    // R1: reset in the middle of a run aborts it
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (100) @(negedge clk);
    chk(busy, "R2", "busy mid-run", busy, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !bus_we && !bus_re, "R1", "reset aborts run",
        {busy, done, bus_we, bus_re}, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule